// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block drives an external serial-in/parallel-out shift register chip with a 17-bit output image. It sends the image out over a serial data line and a serial clock line. The serial clock runs at the internal clock divided by a programmable power of two. A programmable skew sets how long the data is settled before the clock rises. Software controls the block through a small register port: an image register with a read-only busy flag, a divider register, a delay register and a mode register.

The block has two modes. In plain mode, a write to the image register starts one shift. In PWM mode, the image comes from the 17 generator-driven pin outputs. These are sampled every cycle, and a shift starts whenever the sampled image is non-zero and differs from the image last sent. An all-zero image is never sent in PWM mode. Software therefore clears the external chip with a plain-mode shift of zeros before it turns PWM mode on.

Top module: `sled_shifter`

## Requirements
- R1: In plain mode (mode bit 1 = 0), a write to address 0 loads bits [16:0] as the image and starts a shift of 17 bits, most significant bit first. Each bit gets exactly one rising edge of the serial clock, and data is valid at that edge.
- R2: Address 1 bits [1:0] select the bit period N = 4, 8, 16 or 32 internal clocks for codes 0, 1, 2 and 3. Busy (address 0 bit 31) reads 1 from the cycle after the starting edge. It stays 1 for exactly 18·N cycles: 17 bit slots plus one trailing slot.
- R3: Within each bit slot, the data changes at slot start. The clock rises d+1 cycles later, where d is the effective delay, and stays high for N/2−1 cycles.
- R4: Address 2 bits [4:0] hold a raw delay. The effective delay is min(raw, N/2−1), and address 2 reads back the effective value.
- R5: A write to address 0 while busy is ignored: the stored image is unchanged and no further shift follows.
- R6: A mode write that sets bit 1 while busy leaves bit 1 at 0; the other mode bits of that write still apply. Clearing bit 1 is accepted at any time.
- R7: Mode bit 0 (chip-style select) is stored and reads back at address 3 bit 0; address 3 bit 1 reads the PWM enable.
- R8: In PWM mode, a shift starts when the sampled generator image is non-zero and differs from the last image shifted. The bits sent are that generator image.
- R9: In PWM mode, no shift starts for an all-zero generator image or for an image equal to the last one sent. A write to address 0 in PWM mode stores the image but starts no shift.
- R10: The serial clock idles low and is low whenever busy is 0. Serial data never changes while the clock is high or in the cycle the clock falls, and it is 0 once a shift has ended.
- R11: After reset, busy, serial clock, serial data and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read (0 image, 1 divider, 2 delay, 3 mode) |
| reg_wdata_i | input | 17 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| gen_img_i | input | 17 | Generator-driven image for PWM mode |
| ser_data_o | output | 1 | Serial data to the external chip |
| ser_clk_o | output | 1 | Serial clock to the external chip |

## Verification
Each divider code is run with delays at zero, in range and above the legal limit. A design that lost the trailing slot, miscounted the period or left the delay unsaturated would show a wrong busy length or a clock rise in the wrong cycle. Writes to the image and attempts to enter PWM mode are placed in the middle of a shift. A missing lockout would then corrupt the stored image or let the generator image start a shift too early. The PWM tests hold the generator image unchanged, drive it to all zero, and write the image register. A trigger that compared against the wrong image, or did not block zero, would start a shift that should not happen.

// File: rtl/sled_pkg.sv
package sled_pkg;
  localparam int IMG_W    = 17;
  localparam int DIV_W    = 2;
  localparam int DLY_W    = 5;
  localparam int REG_W    = 32;
  localparam int BUSY_BIT = 31;
  localparam int MAX_PER  = 4 << ((1 << DIV_W) - 1);
  localparam int CNT_W    = $clog2(MAX_PER) + 1;
  localparam int BCNT_W   = $clog2(IMG_W + 1);

  typedef enum logic [1:0] {
    RA_IMAGE = 2'd0,
    RA_DIV   = 2'd1,
    RA_DELAY = 2'd2,
    RA_MODE  = 2'd3
  } reg_addr_e;

  function automatic logic [CNT_W-1:0] period_of(input logic [DIV_W-1:0] code);
    return CNT_W'(4) << code;
  endfunction

  function automatic logic [DLY_W-1:0] dly_sat(input logic [DLY_W-1:0] raw,
                                               input logic [DIV_W-1:0] code);
    logic [CNT_W-1:0] lim;
    lim = (period_of(code) >> 1) - CNT_W'(1);
    if (CNT_W'(raw) > lim) return DLY_W'(lim);
    return raw;
  endfunction
endpackage

// File: rtl/sled_regs.sv
module sled_regs #(
  parameter int IW = sled_pkg::IMG_W,
  parameter int DW = sled_pkg::DIV_W,
  parameter int LW = sled_pkg::DLY_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  sled_pkg::reg_addr_e addr_i,
  input  logic [IW-1:0]       wdata_i,
  input  logic                busy_i,
  output logic [IW-1:0]       img_o,
  output logic [DW-1:0]       div_o,
  output logic [LW-1:0]       dly_raw_o,
  output logic                chip_o,
  output logic                pwm_o,
  output logic                start_o,
  output logic [IW-1:0]       start_img_o
);
  import sled_pkg::*;

  logic [IW-1:0] img_q, img_d;
  logic [DW-1:0] div_q, div_d;
  logic [LW-1:0] dly_q, dly_d;
  logic          chip_q, chip_d, pwm_q, pwm_d;
  logic          img_en;

  always_comb begin
    img_d  = img_q;
    div_d  = div_q;
    dly_d  = dly_q;
    chip_d = chip_q;
    pwm_d  = pwm_q;
    img_en = 1'b0;
    start_o = 1'b0;
    if (wr_i) begin
      unique case (addr_i)
        RA_IMAGE: begin
          if (!busy_i) begin
            img_en  = 1'b1;
            img_d   = wdata_i;
            start_o = !pwm_q;
          end
        end
        RA_DIV:   div_d = wdata_i[DW-1:0];
        RA_DELAY: dly_d = wdata_i[LW-1:0];
        RA_MODE: begin
          chip_d = wdata_i[0];
          pwm_d  = wdata_i[1] & (pwm_q | !busy_i);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      img_q  <= '0;
      div_q  <= '0;
      dly_q  <= '0;
      chip_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (img_en) img_q <= img_d;
      div_q  <= div_d;
      dly_q  <= dly_d;
      chip_q <= chip_d;
      pwm_q  <= pwm_d;
    end
  end

  assign img_o       = img_q;
  assign div_o       = div_q;
  assign dly_raw_o   = dly_q;
  assign chip_o      = chip_q;
  assign pwm_o       = pwm_q;
  assign start_img_o = wdata_i;

  AST_NO_PWM_ENTRY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> !$past(busy_i)); // R6
  AST_IMG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(img_q)); // R5
endmodule

// File: rtl/sled_timebase.sv
module sled_timebase #(
  parameter int DW = sled_pkg::DIV_W,
  parameter int LW = sled_pkg::DLY_W,
  parameter int CW = sled_pkg::CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          pulse_ok_i,
  input  logic [DW-1:0] div_i,
  input  logic [LW-1:0] dly_i,
  output logic          slot_end_o,
  output logic          ser_clk_o
);
  import sled_pkg::*;

  logic [CW-1:0] cnt_q, cnt_d, per, half, dly_w;
  logic          clk_q, clk_d;

  always_comb begin
    per        = period_of(div_i);
    half       = per >> 1;
    dly_w      = CW'(dly_i);
    slot_end_o = run_i && (cnt_q >= per - CW'(1));
    cnt_d      = (run_i && !slot_end_o) ? cnt_q + CW'(1) : '0;
    clk_d      = pulse_ok_i && (cnt_d > dly_w) && (cnt_d < dly_w + half);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      clk_q <= clk_d;
    end
  end

  assign ser_clk_o = clk_q;
endmodule

// File: rtl/sled_engine.sv
module sled_engine #(
  parameter int IW = sled_pkg::IMG_W,
  parameter int BW = sled_pkg::BCNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_plain_i,
  input  logic [IW-1:0] plain_img_i,
  input  logic          pwm_mode_i,
  input  logic [IW-1:0] gen_img_i,
  input  logic          slot_end_i,
  output logic          busy_o,
  output logic          pulse_ok_o,
  output logic          ser_data_o
);
  logic          busy_q, busy_d;
  logic [BW-1:0] bcnt_q, bcnt_d;
  logic [IW-1:0] sh_q, sh_d, last_q, last_d, gen_q;
  logic          pwm_start, start;
  logic [IW-1:0] start_img;

  always_comb begin
    pwm_start = pwm_mode_i && !busy_q && (gen_q != '0) && (gen_q != last_q);
    start     = start_plain_i || pwm_start;
    start_img = start_plain_i ? plain_img_i : gen_q;
    busy_d    = busy_q;
    bcnt_d    = bcnt_q;
    sh_d      = sh_q;
    last_d    = last_q;
    if (start) begin
      busy_d = 1'b1;
      bcnt_d = '0;
      sh_d   = start_img;
      last_d = start_img;
    end else if (busy_q && slot_end_i) begin
      if (bcnt_q == BW'(IW)) begin
        busy_d = 1'b0;
      end else begin
        sh_d   = sh_q << 1;
        bcnt_d = bcnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
      sh_q   <= '0;
      last_q <= '0;
      gen_q  <= '0;
    end else begin
      busy_q <= busy_d;
      bcnt_q <= bcnt_d;
      sh_q   <= sh_d;
      last_q <= last_d;
      gen_q  <= gen_img_i;
    end
  end

  assign busy_o     = busy_q;
  assign pulse_ok_o = busy_q && (bcnt_q < BW'(IW));
  assign ser_data_o = sh_q[IW-1];

  AST_BITCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcnt_q <= BW'(IW)); // R1
  AST_BUSY_FALL_AFTER_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(bcnt_q) == BW'(IW))); // R2
  AST_PWM_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_q) && $past(pwm_mode_i)) |-> (sh_q != '0)); // R9
endmodule

// File: rtl/sled_shifter.sv
module sled_shifter (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_wr_i,
  input  logic [1:0]                 reg_addr_i,
  input  logic [sled_pkg::IMG_W-1:0] reg_wdata_i,
  output logic [sled_pkg::REG_W-1:0] reg_rdata_o,
  input  logic [sled_pkg::IMG_W-1:0] gen_img_i,
  output logic                       ser_data_o,
  output logic                       ser_clk_o
);
  import sled_pkg::*;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  reg_addr_e        addr;
  logic [IMG_W-1:0] img, start_img;
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] dly_raw, dly_eff;
  logic             chip, pwm, start, busy, pulse_ok, slot_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n   = rst_sync_q[1];
  assign addr    = reg_addr_e'(reg_addr_i);
  assign dly_eff = dly_sat(dly_raw, div);

  sled_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_i(reg_wr_i), .addr_i(addr),
    .wdata_i(reg_wdata_i), .busy_i(busy), .img_o(img), .div_o(div),
    .dly_raw_o(dly_raw), .chip_o(chip), .pwm_o(pwm), .start_o(start),
    .start_img_o(start_img)
  );

  sled_engine u_engine (
    .clk_i(clk_i), .rst_ni(rst_n), .start_plain_i(start),
    .plain_img_i(start_img), .pwm_mode_i(pwm), .gen_img_i(gen_img_i),
    .slot_end_i(slot_end), .busy_o(busy), .pulse_ok_o(pulse_ok),
    .ser_data_o(ser_data_o)
  );

  sled_timebase u_timebase (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(busy), .pulse_ok_i(pulse_ok),
    .div_i(div), .dly_i(dly_eff), .slot_end_o(slot_end), .ser_clk_o(ser_clk_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      RA_IMAGE: begin
        reg_rdata_o[BUSY_BIT]    = busy;
        reg_rdata_o[IMG_W-1:0]   = img;
      end
      RA_DIV:   reg_rdata_o[DIV_W-1:0] = div;
      RA_DELAY: reg_rdata_o[DLY_W-1:0] = dly_eff;
      RA_MODE:  reg_rdata_o[1:0]       = {pwm, chip};
      default: ;
    endcase
  end

  AST_IDLE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy |-> !ser_clk_o); // R10
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o)); // R10
endmodule

// File: tb/sled_shifter_bench.sv
module sled_shifter_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [16:0] wdata = '0;
  logic [31:0] rdata;
  logic [16:0] gen = '0;
  logic        sdata, sclk;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sled_shifter u_sled_shifter (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .gen_img_i(gen),
    .ser_data_o(sdata), .ser_clk_o(sclk)
  );

  // {div[1:0], raw delay[4:0], image[16:0]}
  localparam logic [23:0] VECS [6] = '{
    {2'd0, 5'd0,  17'h1A5C3},
    {2'd1, 5'd2,  17'h00001},
    {2'd2, 5'd7,  17'h10000},
    {2'd3, 5'd15, 17'h15555},
    {2'd0, 5'd9,  17'h1FFFF},
    {2'd3, 5'd31, 17'h0F0F0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [16:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd0;
    #1;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd0;
    #1;
  endtask

  task automatic capture(output logic [16:0] img, output int pulses, output int first,
                         output int blen, output int viol, output int hi);
    logic pc, pd;
    pc = 1'b0; pd = sdata; img = '0;
    pulses = 0; first = -1; blen = 0; viol = 0; hi = 0;
    for (int t = 0; t < 3000; t++) begin
      if (rdata[31] == 1'b0) break;
      blen++;
      if (sclk) hi++;
      if (sclk && !pc) begin
        pulses++;
        img = {img[15:0], sdata};
        if (first < 0) first = t;
      end
      if ((sdata !== pd) && (sclk || pc)) viol++;
      pc = sclk; pd = sdata;
      @(negedge clk); #1;
    end
  endtask

  task automatic wait_busy(output int waited);
    waited = 0;
    while (rdata[31] == 1'b0 && waited < 10) begin
      @(negedge clk); #1;
      waited++;
    end
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 3000; t++) begin
      if (rdata[31] == 1'b0) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic busy_seen(input int n, output int seen);
    seen = 0;
    for (int t = 0; t < n; t++) begin
      if (rdata[31]) seen = 1;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [16:0] img;
    int pulses, first, blen, viol, hi, waited, seen;

    repeat (4) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R11 reset state
    chk("R11 busy/image", int'(rdata), 0);
    chk("R11 sclk", int'(sclk), 0);
    chk("R11 sdata", int'(sdata), 0);
    reg_read(2'd1, rd); chk("R11 divider", int'(rd), 0);
    reg_read(2'd2, rd); chk("R11 delay", int'(rd), 0);
    reg_read(2'd3, rd); chk("R11 mode", int'(rd), 0);

    // Table walk: plain shifts across dividers and delays
    for (int i = 0; i < 6; i++) begin
      logic [1:0]  dv;
      logic [4:0]  dl;
      logic [16:0] im;
      int n, de;
      {dv, dl, im} = VECS[i];
      n  = 4 << dv;
      de = (int'(dl) > n/2 - 1) ? n/2 - 1 : int'(dl);
      reg_write(2'd1, {15'd0, dv});
      reg_write(2'd2, {12'd0, dl});
      reg_read(2'd2, rd); chk("R4 delay readback", int'(rd), de);
      reg_write(2'd0, im);
      capture(img, pulses, first, blen, viol, hi);
      chk("R1 shifted image", int'(img), int'(im));
      chk("R1 pulse count", pulses, 17);
      chk("R3 first rise", first, de + 1);
      chk("R3 high cycles", hi, 17 * (n/2 - 1));
      chk("R2 busy length", blen, 18 * n);
      chk("R10 data vs clock", viol, 0);
      chk("R10 idle data", int'(sdata), 0);
      chk("R10 idle clock", int'(sclk), 0);
    end

    // R5: image write during busy is ignored
    reg_write(2'd1, 17'd0);
    reg_write(2'd2, 17'd0);
    reg_write(2'd0, 17'h0AAAA);
    repeat (10) @(negedge clk); #1;
    reg_write(2'd0, 17'h1FFFF);
    wait_idle();
    busy_seen(10, seen); chk("R5 no second shift", seen, 0);
    reg_read(2'd0, rd); chk("R5 image kept", int'(rd), 'h0AAAA);

    // R6 / R7: PWM entry blocked while busy, chip bit still written
    reg_write(2'd0, 17'h00000);
    repeat (5) @(negedge clk); #1;
    reg_write(2'd3, 17'd3);
    reg_read(2'd3, rd); chk("R6 pwm entry blocked, R7 chip bit", int'(rd), 1);
    wait_idle();
    reg_write(2'd3, 17'd0);
    reg_read(2'd3, rd); chk("R7 mode cleared", int'(rd), 0);

    // R8: PWM mode shifts the generator image
    gen = 17'h12345;
    reg_write(2'd3, 17'd2);
    wait_busy(waited);
    chk("R8 pwm start seen", int'(rdata[31]), 1);
    capture(img, pulses, first, blen, viol, hi);
    chk("R8 pwm image", int'(img), 'h12345);
    chk("R8 pwm pulses", pulses, 17);

    // R9: unchanged, zero, and register writes start nothing
    busy_seen(40, seen); chk("R9 unchanged image", seen, 0);
    gen = 17'h0;
    busy_seen(40, seen); chk("R9 zero image", seen, 0);
    reg_write(2'd0, 17'h00F00);
    busy_seen(20, seen); chk("R9 write in pwm mode", seen, 0);
    reg_read(2'd0, rd); chk("R9 image stored", int'(rd), 'h00F00);

    gen = 17'h00777;
    wait_busy(waited);
    capture(img, pulses, first, blen, viol, hi);
    chk("R8 changed image", int'(img), 'h00777);

    // R6: leaving PWM mode is allowed mid-shift
    gen = 17'h00001;
    wait_busy(waited);
    chk("R8 third start", int'(rdata[31]), 1);
    reg_write(2'd3, 17'd0);
    reg_read(2'd3, rd); chk("R6 pwm cleared while busy", int'(rd), 0);
    wait_idle();
    chk("R10 idle clock after", int'(sclk), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule